// File: doc/BRIEF.md
# Multi-Level Trigger Busy Sequencer

This block follows a single event through a three-stage trigger decision in a detector readout concentrator. A level-0 pulse taken while the block is free raises BUSY and fires a start-encoding strobe. After that, the block waits for a first-level decision and then a second-level decision. Each decision comes as a single-cycle accept or reject pulse. An accepted event stays busy while it is being built, until the downstream data path returns a done pulse. At that point the block fires a commit strobe and becomes free again. A first-level reject ends the event early, but BUSY is held until a minimum release time after level 0 has passed. A second-level reject cancels event building at once.

Every wait is bounded by a counter of clock cycles since level 0. The block has three such limits: the first-level window, the second-level window and the overall busy limit. If one of these expires, the block fires the cancel strobe, sets a sticky timeout flag and returns to idle. Pulses that arrive while the block cannot use them are dropped. A level-0 pulse dropped while busy is counted in a saturating counter. A decision pulse that comes in the wrong phase sets a sticky protocol-error flag.

All limits are parameters in clock cycles. The defaults assume a 40 MHz clock: 320 cycles for the first level, 3600 for the second level, 4000 for the whole busy period, and 240 for the minimum hold after a first-level reject.

Top module: `trig_busy_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy_o`, all strobes and both error flags are 0 and `l0_drop_cnt_o` is 0.
- R2: An `l0_i` pulse taken while `busy_o` is 0 makes `busy_o` 1 and `enc_start_o` 1 in the next cycle. `enc_start_o` is high for exactly that one cycle.
- R3: The cycles after the one carrying `l0_i` are numbered 1, 2, and so on. A first-level reject in cycle r gives `cancel_o` in cycle r+1. `busy_o` first reads 0 in cycle max(r+1, REJ_HOLD+1).
- R4: After a first-level accept, a second-level reject in cycle s gives `cancel_o` in cycle s+1, and `busy_o` reads 0 from cycle s+1.
- R5: After a second-level accept, a `done_i` in cycle d gives `commit_o` in cycle d+1, and `busy_o` reads 0 from cycle d+1. `cancel_o` is not raised for that event.
- R6: A first-level decision is used if it arrives in a cycle up to and including L1_WIN. If none has come by then, `cancel_o` and `timeout_err_o` are 1 and `busy_o` is 0 in cycle L1_WIN+1.
- R7: Likewise, a second-level decision is used up to cycle L2_WIN. If none has come, a cancel and a timeout follow in cycle L2_WIN+1.
- R8: After a second-level accept with no `done_i` up to cycle BUSY_MAX, a cancel and a timeout follow in cycle BUSY_MAX+1. `busy_o` is never high for more than BUSY_MAX consecutive cycles.
- R9: An `l0_i` pulse while `busy_o` is 1 has no effect on the event in progress. It increments `l0_drop_cnt_o` by one in the next cycle, and the counter holds at 255.
- R10: An accept or reject pulse of a level the current phase is not waiting for has no effect on `busy_o` or the strobes, and it sets `proto_err_o` in the next cycle. `done_i` outside the building phase has no effect and sets no flag.
- R11: If an accept and a reject of the same level arrive in the same cycle, the reject is taken.
- R12: `timeout_err_o` and `proto_err_o` stay 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l0_i | input | 1 | Level-0 trigger pulse |
| l1_acc_i | input | 1 | First-level accept pulse |
| l1_rej_i | input | 1 | First-level reject pulse |
| l2_acc_i | input | 1 | Second-level accept pulse |
| l2_rej_i | input | 1 | Second-level reject pulse |
| done_i | input | 1 | Downstream event-building finished |
| busy_o | output | 1 | Readout busy |
| enc_start_o | output | 1 | Start front-end encoding strobe |
| commit_o | output | 1 | Event complete strobe |
| cancel_o | output | 1 | Abandon event strobe |
| timeout_err_o | output | 1 | Sticky window-expired flag |
| proto_err_o | output | 1 | Sticky out-of-phase decision flag |
| l0_drop_cnt_o | output | DROP_W | Saturating count of dropped level-0 pulses |

## Verification
The bench works on the edges of each window. It sends decisions in exactly the last allowed cycle and, in other runs, sends none at all. An off-by-one compare would then either cancel a valid event or hold BUSY one cycle too long. It sends first-level rejects both before and after the minimum hold time. A design that ignored the hold would drop BUSY too early, and one that always waited in the hold phase would drop it late. Other cases are level-0 floods that push the drop counter past 255, where a missing saturation would wrap to a small value, and accept and reject pulses arriving together. Misplaced decisions and idle done pulses must leave BUSY and the strobes untouched, while they set or leave the protocol flag as R10 states.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WAIT_L1 = 3'd1,
        PH_WAIT_L2 = 3'd2,
        PH_BUILD   = 3'd3,
        PH_HOLD    = 3'd4
    } phase_e;

    // Pulses sampled in one cycle
    typedef struct packed {
        logic l0;
        logic l1_acc;
        logic l1_rej;
        logic l2_acc;
        logic l2_rej;
        logic done;
    } trig_in_t;

    // Decisions taken by the sequencer in one cycle
    typedef struct packed {
        logic enc_start;
        logic commit;
        logic cancel;
        logic timeout;
        logic proto;
    } seq_evt_t;

    localparam int NUM_LIMITS = 4;
    localparam int LIM_L1     = 0;
    localparam int LIM_L2     = 1;
    localparam int LIM_BUSY   = 2;
    localparam int LIM_HOLD   = 3;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic l1_any(input trig_in_t t);
        return t.l1_acc | t.l1_rej;
    endfunction

    function automatic logic l2_any(input trig_in_t t);
        return t.l2_acc | t.l2_rej;
    endfunction

endpackage

// File: rtl/trig_win_timer.sv
module trig_win_timer
    import trig_seq_pkg::*;
#(
    parameter int unsigned L1_WIN   = 320,
    parameter int unsigned L2_WIN   = 3600,
    parameter int unsigned BUSY_MAX = 4000,
    parameter int unsigned REJ_HOLD = 240
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  restart,
    output logic [NUM_LIMITS-1:0] due
);
    localparam int unsigned TOP   = max4(L1_WIN, L2_WIN, BUSY_MAX, REJ_HOLD);
    localparam int          CNT_W = $clog2(TOP + 1) + 1;
    localparam int unsigned LIMS [NUM_LIMITS] = '{L1_WIN, L2_WIN, BUSY_MAX, REJ_HOLD};

    logic [CNT_W-1:0] elapsed;
    logic             at_top;

    assign at_top = (elapsed >= CNT_W'(TOP));

    // elapsed = cycles since the level-0 capture edge, minus one
    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else if (!at_top) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // due[i]: the current cycle is the last one inside window i
    for (genvar i = 0; i < NUM_LIMITS; i++) begin : g_cmp
        assign due[i] = (elapsed >= CNT_W'(LIMS[i] - 1));
    end

endmodule

// File: rtl/trig_sat_counter.sv
module trig_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] FULL = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && cnt != FULL) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
    import trig_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  trig_in_t              trg,
    input  logic [NUM_LIMITS-1:0] due,
    output logic                  restart,
    output phase_e                phase,
    output seq_evt_t              evt_q,
    output logic                  timeout_q,
    output logic                  proto_q
);
    phase_e   nxt;
    seq_evt_t ev;

    always_comb begin
        nxt     = phase;
        ev      = '0;
        restart = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (trg.l0) begin
                    nxt          = PH_WAIT_L1;
                    ev.enc_start = 1'b1;
                    restart      = 1'b1;
                end
                ev.proto = l1_any(trg) | l2_any(trg);
            end
            PH_WAIT_L1: begin
                if (trg.l1_rej) begin
                    ev.cancel = 1'b1;
                    nxt       = due[LIM_HOLD] ? PH_IDLE : PH_HOLD;
                end else if (trg.l1_acc) begin
                    nxt = PH_WAIT_L2;
                end else if (due[LIM_L1]) begin
                    ev.cancel  = 1'b1;
                    ev.timeout = 1'b1;
                    nxt        = PH_IDLE;
                end
                ev.proto = l2_any(trg);
            end
            PH_WAIT_L2: begin
                if (trg.l2_rej) begin
                    ev.cancel = 1'b1;
                    nxt       = PH_IDLE;
                end else if (trg.l2_acc) begin
                    nxt = PH_BUILD;
                end else if (due[LIM_L2]) begin
                    ev.cancel  = 1'b1;
                    ev.timeout = 1'b1;
                    nxt        = PH_IDLE;
                end
                ev.proto = l1_any(trg);
            end
            PH_BUILD: begin
                if (trg.done) begin
                    ev.commit = 1'b1;
                    nxt       = PH_IDLE;
                end else if (due[LIM_BUSY]) begin
                    ev.cancel  = 1'b1;
                    ev.timeout = 1'b1;
                    nxt        = PH_IDLE;
                end
                ev.proto = l1_any(trg) | l2_any(trg);
            end
            PH_HOLD: begin
                if (due[LIM_HOLD]) begin
                    nxt = PH_IDLE;
                end
                ev.proto = l1_any(trg) | l2_any(trg);
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            evt_q     <= '0;
            timeout_q <= 1'b0;
            proto_q   <= 1'b0;
        end else begin
            phase     <= nxt;
            evt_q     <= ev;
            timeout_q <= timeout_q | ev.timeout;
            proto_q   <= proto_q | ev.proto;
        end
    end

endmodule

// File: rtl/trig_busy_seq.sv
module trig_busy_seq
    import trig_seq_pkg::*;
#(
    parameter int unsigned L1_WIN   = 320,
    parameter int unsigned L2_WIN   = 3600,
    parameter int unsigned BUSY_MAX = 4000,
    parameter int unsigned REJ_HOLD = 240,
    parameter int          DROP_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l0_i,
    input  logic              l1_acc_i,
    input  logic              l1_rej_i,
    input  logic              l2_acc_i,
    input  logic              l2_rej_i,
    input  logic              done_i,
    output logic              busy_o,
    output logic              enc_start_o,
    output logic              commit_o,
    output logic              cancel_o,
    output logic              timeout_err_o,
    output logic              proto_err_o,
    output logic [DROP_W-1:0] l0_drop_cnt_o
);
    trig_in_t              trg;
    logic [NUM_LIMITS-1:0] due;
    logic                  restart;
    phase_e                phase;
    seq_evt_t              evt_q;

    assign trg = '{l0: l0_i, l1_acc: l1_acc_i, l1_rej: l1_rej_i,
                   l2_acc: l2_acc_i, l2_rej: l2_rej_i, done: done_i};

    trig_win_timer #(
        .L1_WIN  (L1_WIN),
        .L2_WIN  (L2_WIN),
        .BUSY_MAX(BUSY_MAX),
        .REJ_HOLD(REJ_HOLD)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .due    (due)
    );

    trig_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .trg      (trg),
        .due      (due),
        .restart  (restart),
        .phase    (phase),
        .evt_q    (evt_q),
        .timeout_q(timeout_err_o),
        .proto_q  (proto_err_o)
    );

    trig_sat_counter #(.W(DROP_W)) u_drop (
        .clk(clk),
        .rst(rst),
        .inc(trg.l0 && phase != PH_IDLE),
        .cnt(l0_drop_cnt_o)
    );

    assign busy_o      = (phase != PH_IDLE);
    assign enc_start_o = evt_q.enc_start;
    assign commit_o    = evt_q.commit;
    assign cancel_o    = evt_q.cancel;

endmodule

// File: rtl/trig_busy_seq_chk.sv
module trig_busy_seq_chk #(
    parameter int unsigned BUSY_MAX = 4000,
    parameter int          DROP_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              l0_i,
    input logic              busy_o,
    input logic              enc_start_o,
    input logic              commit_o,
    input logic              cancel_o,
    input logic              timeout_err_o,
    input logic              proto_err_o,
    input logic [DROP_W-1:0] l0_drop_cnt_o
);
    localparam logic [DROP_W-1:0] FULL = '1;

    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) run_len <= 0;
        else                run_len <= run_len + 1;
    end

    assert_l0_starts_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && l0_i) |=> (busy_o && enc_start_o));

    assert_enc_single_R2: assert property (@(posedge clk) disable iff (rst)
        enc_start_o |=> !enc_start_o);

    assert_commit_frees_R5: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> (!busy_o && !cancel_o));

    assert_busy_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        run_len <= BUSY_MAX);

    assert_drop_count_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && l0_i && l0_drop_cnt_o != FULL) |=> (l0_drop_cnt_o == $past(l0_drop_cnt_o) + 1'b1));

    assert_drop_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (l0_drop_cnt_o == FULL) |=> (l0_drop_cnt_o == FULL));

    assert_timeout_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        timeout_err_o |=> timeout_err_o);

    assert_proto_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |=> proto_err_o);

endmodule

bind trig_busy_seq trig_busy_seq_chk #(
    .BUSY_MAX(BUSY_MAX),
    .DROP_W  (DROP_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .l0_i         (l0_i),
    .busy_o       (busy_o),
    .enc_start_o  (enc_start_o),
    .commit_o     (commit_o),
    .cancel_o     (cancel_o),
    .timeout_err_o(timeout_err_o),
    .proto_err_o  (proto_err_o),
    .l0_drop_cnt_o(l0_drop_cnt_o)
);

// File: tb/test_trig_busy_seq.sv
module test_trig_busy_seq;
    localparam int CLK_PERIOD = 10;
    localparam int L1W = 20;
    localparam int L2W = 120;
    localparam int BMX = 200;
    localparam int RHD = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l0 = 0, l1a = 0, l1r = 0, l2a = 0, l2r = 0, dn = 0;
    logic busy, enc, commit, cancel, to_err, pr_err;
    logic [7:0] drops;

    int n_chk = 0;
    int n_fail = 0;
    int exp_drop = 0;
    bit exp_to = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trig_busy_seq #(.L1_WIN(L1W), .L2_WIN(L2W), .BUSY_MAX(BMX), .REJ_HOLD(RHD), .DROP_W(8)) i_trig_busy_seq (
        .clk(clk), .rst(rst), .l0_i(l0), .l1_acc_i(l1a), .l1_rej_i(l1r),
        .l2_acc_i(l2a), .l2_rej_i(l2r), .done_i(dn), .busy_o(busy),
        .enc_start_o(enc), .commit_o(commit), .cancel_o(cancel),
        .timeout_err_o(to_err), .proto_err_o(pr_err), .l0_drop_cnt_o(drops));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // kinds: 0 L1 reject, 1 L2 reject, 2 commit, 3 L1 timeout, 4 L2 timeout, 5 busy timeout
    function automatic string req_of(input int kind);
        case (kind)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic int exp_release(input int kind, input int d1, input int d2, input int d3);
        case (kind)
            0: return (d1 + 1 > RHD + 1) ? d1 + 1 : RHD + 1;
            1: return d2 + 1;
            2: return d3 + 1;
            3: return L1W + 1;
            4: return L2W + 1;
            default: return BMX + 1;
        endcase
    endfunction

    function automatic int exp_strobe(input int kind, input int d1, input int d2, input int d3);
        case (kind)
            0: return d1 + 1;
            1: return d2 + 1;
            2: return d3 + 1;
            default: return exp_release(kind, d1, d2, d3);
        endcase
    endfunction

    task automatic drive_zero();
        l0 = 0; l1a = 0; l1r = 0; l2a = 0; l2r = 0; dn = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); drive_zero(); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
        exp_drop = 0; exp_to = 0;
    endtask

    // inject: 0 none, 1 every fourth busy cycle, 2 every busy cycle; both: accept with reject (R11)
    task automatic run_event(input int kind, input int d1, input int d2, input int d3,
                             input int inject, input bit both);
        int rel = exp_release(kind, d1, d2, d3);
        int stb = exp_strobe(kind, d1, d2, d3);
        int got_rel = 0, got_can = 0, got_com = 0, got_enc = 0, n_enc = 0;
        string rq = req_of(kind);
        for (int c = 0; c <= rel; c++) begin
            @(negedge clk);
            if (c >= 1) begin
                if (!busy && got_rel == 0) got_rel = c;
                if (cancel && got_can == 0) got_can = c;
                if (commit && got_com == 0) got_com = c;
                if (enc) begin n_enc++; if (got_enc == 0) got_enc = c; end
            end
            drive_zero();
            if (c == 0) l0 = 1;
            else if (c < rel && ((inject == 1 && c % 4 == 2) || inject == 2)) begin
                l0 = 1;
                if (exp_drop < 255) exp_drop++;
            end
            if (c == d1 && kind != 3) begin
                if (kind == 0) begin l1r = 1; l1a = both; end
                else l1a = 1;
            end
            if (c == d2 && (kind == 1 || kind == 2 || kind == 5)) begin
                if (kind == 1) begin l2r = 1; l2a = both; end
                else l2a = 1;
            end
            if (c == d3 && kind == 2) dn = 1;
        end
        drive_zero();
        if (kind >= 3) exp_to = 1;
        chk("R2", "enc_start cycle", got_enc, 1);
        chk("R2", "enc_start pulses", n_enc, 1);
        chk(rq, "busy release cycle", got_rel, rel);
        if (kind == 2) begin
            chk("R5", "commit cycle", got_com, stb);
            chk("R5", "no cancel on commit", got_can, 0);
        end else begin
            chk(rq, "cancel cycle", got_can, stb);
            chk(rq, "no commit", got_com, 0);
        end
        if (both) chk("R11", "reject wins release", got_rel, rel);
        chk("R12", "timeout flag", int'(to_err), int'(exp_to));
        chk("R9", "drop count", int'(drops), exp_drop);
        chk("R10", "proto flag clear", int'(pr_err), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20051226);
        @(negedge clk); @(negedge clk);
        chk("R1", "busy in reset", int'(busy), 0);
        rst = 0;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "strobes after reset", int'({enc, commit, cancel}), 0);
        chk("R1", "flags after reset", int'({to_err, pr_err}), 0);
        chk("R1", "drop count after reset", int'(drops), 0);

        // directed windows and edges
        run_event(0, 5, 0, 0, 0, 0);          // release waits for hold
        run_event(0, L1W, 0, 0, 0, 0);        // late reject, immediate release
        run_event(1, L1W, L2W, 0, 0, 0);      // both decisions in last legal cycle
        run_event(2, 3, 50, BMX, 1, 0);       // done in last legal cycle
        run_event(0, 4, 0, 0, 0, 1);          // R11 level one
        run_event(1, 2, 9, 0, 0, 1);          // R11 level two
        run_event(3, 0, 0, 0, 0, 0);          // no L1
        run_event(2, 1, 2, 3, 0, 0);          // R12 flag still set
        run_event(4, 7, 0, 0, 1, 0);          // no L2
        run_event(5, 6, 60, 0, 0, 0);         // no done

        // constrained random
        for (int e = 0; e < 40; e++) begin
            int k  = int'($urandom_range(5, 0));
            int d1 = int'($urandom_range(L1W, 1));
            int d2 = d1 + 1 + int'($urandom_range(L2W - d1 - 1, 0));
            int d3 = d2 + 1 + int'($urandom_range(BMX - d2 - 1, 0));
            run_event(k, d1, d2, d3, int'($urandom_range(1, 0)), bit'($urandom_range(1, 0)));
        end

        // drop counter saturation
        do_reset();
        run_event(5, 1, 2, 0, 2, 0);
        run_event(5, 1, 2, 0, 2, 0);
        chk("R9", "drop saturated", int'(drops), 255);

        // out-of-phase pulses
        do_reset();
        @(negedge clk); dn = 1;
        @(negedge clk); dn = 0;
        @(negedge clk);
        chk("R10", "idle done busy", int'(busy), 0);
        chk("R10", "idle done no flag", int'(pr_err), 0);
        @(negedge clk); l2r = 1;
        @(negedge clk); l2r = 0;
        chk("R10", "idle L2 sets flag", int'(pr_err), 1);
        chk("R10", "idle L2 no busy", int'(busy), 0);
        chk("R10", "idle L2 no strobe", int'({enc, commit, cancel}), 0);
        do_reset();
        @(negedge clk); l0 = 1;
        @(negedge clk); l0 = 0; l2a = 1;
        @(negedge clk); l2a = 0;
        chk("R10", "L2 while waiting L1 flag", int'(pr_err), 1);
        chk("R10", "L2 while waiting L1 busy", int'(busy), 1);
        @(negedge clk); l1r = 1;
        @(negedge clk); l1r = 0;
        chk("R10", "event still decided by L1", int'(cancel), 1);
        @(negedge clk);
        chk("R12", "proto flag sticky", int'(pr_err), 1);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R1", "reset clears proto", int'(pr_err), 0);
        chk("R1", "reset clears busy", int'(busy), 0);

        report();
        $finish;
    end

endmodule